// File: doc/BRIEF.md
# Register-Controlled PWM Generator

This block drives one pulse-width-modulated pin from two byte-wide registers. The control register turns the generator on and off and picks the idle level. It also selects between normal PWM and a fixed square-wave mode, and sets a power-of-two clock prescale. The duty register sets the high time of each 256-tick period. A host writes and reads the two registers through a plain address / write-enable / data port. The system clock runs the prescaler and the period counter. A separate oscillator clock feeds the square-wave mode.

The prescaler makes a one-cycle tick every 2^N system cycles, with N from 0 to 15. Each tick advances an 8-bit period counter. The output is high while the counter is at or below the active duty value, so a duty of D gives a high time of D+1 ticks out of 256. A new duty value is copied into the active copy only when the counter wraps, so no period is ever cut short. While the generator is disabled or the sleep input is high, the counters are cleared and the pin rests at the selected idle level. The next enabled period therefore starts cleanly at count 0.

Top module: `pwm_regctl`

## Requirements
- R1: After reset both registers read 00h and `pwm_out` is low.
- R2: Address 0 selects the control register and address 1 the duty register. Written values read back unchanged, except control bit 5, which always reads 0.
- R3: With control bit 7 = 1, bit 4 = 0 and `sleep` low, each period lasts 256 counter ticks. The output is high for the first D+1 ticks, where D is the duty value, so FFh gives a constant high.
- R4: One counter tick lasts 2^N system-clock cycles, where N is control bits 3:0. N = 0 advances the counter every cycle.
- R5: When control bit 4 = 0 and either control bit 7 = 0 or `sleep` = 1, `pwm_out` holds control bit 6 (0 = low, 1 = high).
- R6: When control bit 4 = 1, `pwm_out` is a square wave that changes level every 8 `osc_clk` rising edges, whatever the state of bit 7 and `sleep`.
- R7: A duty write takes effect at the next counter wrap from 255 to 0. A write that lands on the wrap edge itself takes effect one period later.
- R8: Disabling or sleeping clears the prescaler and the period counter. After re-enable, the output starts a new period at count 0, so it is high first.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset, for both clock domains |
| osc_clk | input | 1 | Oscillator clock for the square-wave mode |
| sleep | input | 1 | Sleep request; forces the idle level in PWM mode |
| reg_addr | input | 1 | Register select: 0 = control, 1 = duty |
| reg_we | input | 1 | Register write strobe |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Read data of the selected register |
| pwm_out | output | 1 | PWM / square-wave / idle-level output |

## Verification
A duty-register write and the counter wrap that copies the duty register into the active copy can happen on the same clock edge. The bench provokes this by timing a write so that it is registered on the very edge where the counter leaves 255. The period that follows must still use the old duty value, and the new value must appear only one period later. A second write in the middle of a period is also checked: it must leave the rest of that period untouched and control the whole of the next one.

// File: rtl/pwm_regctl_pkg.sv
// Package pwm_regctl_pkg
// Shared definitions for the PWM generator: register selector codes and
// control-register bit positions. Assumes an 8-bit control layout where
// the prescale code sits in the low bits.
package pwm_regctl_pkg;

    typedef enum logic {
        REG_CTRL = 1'b0,
        REG_DUTY = 1'b1
    } reg_sel_e;

    localparam int BIT_EN   = 7;
    localparam int BIT_IDLE = 6;
    localparam int BIT_RSVD = 5;
    localparam int BIT_FIX  = 4;

endpackage

// File: rtl/pwm_regfile.sv
// Module pwm_regfile
// Holds the control and duty registers, returns read data for the
// selected one and breaks the control register into its fields.
// Assumes DATA_W >= 8 and SEL_W <= 4, so the prescale code fits below
// the mode bit.
module pwm_regfile
    import pwm_regctl_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int SEL_W  = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_addr,
    input  logic              reg_we,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] reg_rdata,
    output logic              en_q,
    output logic              idle_q,
    output logic              fix_q,
    output logic [SEL_W-1:0]  sel_q,
    output logic [DATA_W-1:0] duty_q
);

    localparam logic [DATA_W-1:0] RSVD_CLR = ~(DATA_W'(1) << BIT_RSVD);

    logic [DATA_W-1:0] ctrl_q;

    // Register writes; the reserved control bit is never stored
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl_q <= '0;
            duty_q <= '0;
        end else if (reg_we) begin
            if (reg_addr == REG_CTRL) ctrl_q <= reg_wdata & RSVD_CLR;
            else                      duty_q <= reg_wdata;
        end
    end

    // Read multiplexer for the selected register
    always_comb begin
        reg_rdata = (reg_addr == REG_CTRL) ? ctrl_q : duty_q;
    end

    assign en_q   = ctrl_q[BIT_EN];
    assign idle_q = ctrl_q[BIT_IDLE];
    assign fix_q  = ctrl_q[BIT_FIX];
    assign sel_q  = ctrl_q[SEL_W-1:0];

endmodule

// File: rtl/pwm_prescaler.sv
// Module pwm_prescaler
// Free-running divide counter that makes a one-cycle tick every 2^sel
// system cycles while run is high. It is held at zero while run is low,
// so the first tick after start comes 2^sel - 1 cycles later.
// Assumes PRE_W = 2^SEL_W - 1 (the widest divide needs PRE_W low bits).
module pwm_prescaler #(
    parameter int SEL_W = 4,
    parameter int PRE_W = (1 << SEL_W) - 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic [SEL_W-1:0] sel,
    output logic             tick
);

    logic [PRE_W-1:0] div_q;
    logic [PRE_W-1:0] mask;

    // Low-bit mask for the selected divide; the top code wraps to all ones
    always_comb begin
        mask = (PRE_W'(1) << sel) - PRE_W'(1);
    end

    // Divide counter: counts while running, cleared otherwise
    always_ff @(posedge clk) begin
        if (!rst_n || !run) div_q <= '0;
        else                div_q <= div_q + PRE_W'(1);
    end

    // Tick when all selected low bits are set
    always_comb begin
        tick = run && ((div_q & mask) == mask);
    end

endmodule

// File: rtl/pwm_period_core.sv
// Module pwm_period_core
// Period counter and duty comparator. The counter advances on each
// prescaler tick and wraps after 2^DATA_W ticks. The active duty copy
// follows the duty register while idle and is reloaded only on a wrap.
// Assumes tick is never high while run is low.
module pwm_period_core #(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              run,
    input  logic              tick,
    input  logic [DATA_W-1:0] duty_q,
    output logic [DATA_W-1:0] ctr_q,
    output logic [DATA_W-1:0] duty_act,
    output logic              cmp_hi
);

    logic wrap;

    assign wrap = tick && (&ctr_q);

    // Period counter: cleared while idle, advanced per tick
    always_ff @(posedge clk) begin
        if (!rst_n || !run) ctr_q <= '0;
        else if (tick)      ctr_q <= ctr_q + DATA_W'(1);
    end

    // Active duty: tracks the register while idle, latched at each wrap
    always_ff @(posedge clk) begin
        if (!rst_n)            duty_act <= '0;
        else if (!run || wrap) duty_act <= duty_q;
    end

    // Comparator: high while the count has not passed the duty value
    always_comb begin
        cmp_hi = (ctr_q <= duty_act);
    end

endmodule

// File: rtl/pwm_oscdiv.sv
// Module pwm_oscdiv
// Square-wave source in the oscillator domain. It flips its output once
// every 2^OSC_W oscillator edges, so the full wave has a period of
// 2^(OSC_W+1) edges. Assumes rst_n is held low for several oscillator
// cycles, since the reset is sampled in this domain.
module pwm_oscdiv #(
    parameter int OSC_W = 3
) (
    input  logic osc_clk,
    input  logic rst_n,
    output logic sq_q
);

    logic [OSC_W-1:0] oc_q;

    // Edge counter and output flop, flipped when the counter wraps
    always_ff @(posedge osc_clk) begin
        if (!rst_n) begin
            oc_q <= '0;
            sq_q <= 1'b0;
        end else begin
            oc_q <= oc_q + OSC_W'(1);
            if (&oc_q) sq_q <= ~sq_q;
        end
    end

endmodule

// File: rtl/pwm_regctl.sv
// Module pwm_regctl (top)
// Register-controlled PWM generator: register file, power-of-two
// prescaler, period counter with wrap-latched duty, oscillator square
// wave and the final output selector. The mode bit overrides everything.
// Otherwise the generator runs only when enabled and not asleep, and
// shows the idle level when it is not running. The output selector is
// combinational across the two clock domains; the mode bit is expected
// to change rarely.
module pwm_regctl #(
    parameter int DATA_W = 8,
    parameter int SEL_W  = 4,
    parameter int OSC_W  = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              osc_clk,
    input  logic              sleep,
    input  logic              reg_addr,
    input  logic              reg_we,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] reg_rdata,
    output logic              pwm_out
);

    logic              en_q;
    logic              idle_q;
    logic              fix_q;
    logic [SEL_W-1:0]  sel_q;
    logic [DATA_W-1:0] duty_q;
    logic              run;
    logic              tick;
    logic [DATA_W-1:0] ctr_q;
    logic [DATA_W-1:0] duty_act;
    logic              pwm_raw;
    logic              osc_sq;

    pwm_regfile #(.DATA_W(DATA_W), .SEL_W(SEL_W)) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .reg_addr  (reg_addr),
        .reg_we    (reg_we),
        .reg_wdata (reg_wdata),
        .reg_rdata (reg_rdata),
        .en_q      (en_q),
        .idle_q    (idle_q),
        .fix_q     (fix_q),
        .sel_q     (sel_q),
        .duty_q    (duty_q)
    );

    // Run condition: enabled, awake and in PWM mode
    always_comb begin
        run = en_q && !sleep && !fix_q;
    end

    pwm_prescaler #(.SEL_W(SEL_W)) u_pre (
        .clk   (clk),
        .rst_n (rst_n),
        .run   (run),
        .sel   (sel_q),
        .tick  (tick)
    );

    pwm_period_core #(.DATA_W(DATA_W)) u_core (
        .clk      (clk),
        .rst_n    (rst_n),
        .run      (run),
        .tick     (tick),
        .duty_q   (duty_q),
        .ctr_q    (ctr_q),
        .duty_act (duty_act),
        .cmp_hi   (pwm_raw)
    );

    pwm_oscdiv #(.OSC_W(OSC_W)) u_osc (
        .osc_clk (osc_clk),
        .rst_n   (rst_n),
        .sq_q    (osc_sq)
    );

    // Output selector: square wave, running PWM or idle level
    always_comb begin
        if (fix_q)    pwm_out = osc_sq;
        else if (run) pwm_out = pwm_raw;
        else          pwm_out = idle_q;
    end

endmodule

// File: rtl/pwm_regctl_chk.sv
// Module pwm_regctl_chk
// Property checker for pwm_regctl, attached with the bind below. It
// observes ports and the signals that join the sub-blocks.
module pwm_regctl_chk #(
    parameter int DATA_W = 8,
    parameter int SEL_W  = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic              reg_addr,
    input logic              reg_we,
    input logic [DATA_W-1:0] reg_wdata,
    input logic [DATA_W-1:0] reg_rdata,
    input logic              pwm_out,
    input logic              en_q,
    input logic              idle_q,
    input logic              fix_q,
    input logic [SEL_W-1:0]  sel_q,
    input logic [DATA_W-1:0] duty_q,
    input logic              run,
    input logic              tick,
    input logic [DATA_W-1:0] ctr_q,
    input logic [DATA_W-1:0] duty_act
);

    // R2: a duty write is held in the duty register
    p_wr_duty_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_we && reg_addr) |=> (duty_q == $past(reg_wdata)));

    // R2: a control write lands in the control fields
    p_wr_ctrl_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_we && !reg_addr) |=> (en_q == $past(reg_wdata[7]) && idle_q == $past(reg_wdata[6])
                                   && fix_q == $past(reg_wdata[4]) && sel_q == $past(reg_wdata[SEL_W-1:0])));

    // R2: the reserved control bit always reads zero
    p_rsvd_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !reg_addr |-> !reg_rdata[5]);

    // R3: a full-scale active duty keeps the running output high
    p_full_high_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (run && (&duty_act)) |-> pwm_out);

    // R4: every tick advances the period counter by one
    p_ctr_step_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (run && tick) |=> (!run || ctr_q == $past(ctr_q) + DATA_W'(1)));

    // R5: the idle level shows whenever PWM mode is not running
    p_idle_level_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (!fix_q && !run) |-> (pwm_out == idle_q));

    // R7: the active duty changes only across a wrap
    p_duty_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (run && $past(run) && !$past(tick && (&ctr_q))) |-> $stable(duty_act));

    // R8: every start of running begins at count zero
    p_restart_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(run) |-> (ctr_q == '0));

endmodule

bind pwm_regctl pwm_regctl_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .reg_addr  (reg_addr),
    .reg_we    (reg_we),
    .reg_wdata (reg_wdata),
    .reg_rdata (reg_rdata),
    .pwm_out   (pwm_out),
    .en_q      (en_q),
    .idle_q    (idle_q),
    .fix_q     (fix_q),
    .sel_q     (sel_q),
    .duty_q    (duty_q),
    .run       (run),
    .tick      (tick),
    .ctr_q     (ctr_q),
    .duty_act  (duty_act)
);

// File: tb/sim_pwm_regctl.sv
`timescale 1ns/100ps
module sim_pwm_regctl;

    logic       clk = 1'b0;
    logic       osc_clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       sleep = 1'b0;
    logic       reg_addr = 1'b0;
    logic       reg_we = 1'b0;
    logic [7:0] reg_wdata = 8'h00;
    logic [7:0] reg_rdata;
    logic       pwm_out;

    int n_run = 0;
    int n_fail = 0;
    bit done = 1'b0;

    // Vectors {prescale code, duty, expected high cycles}
    localparam int NVEC = 6;
    localparam logic [23:0] VEC [NVEC] = '{
        {4'd0, 8'h00, 12'd1},
        {4'd0, 8'h7F, 12'd128},
        {4'd0, 8'hFF, 12'd256},
        {4'd1, 8'h03, 12'd8},
        {4'd2, 8'h10, 12'd68},
        {4'd3, 8'hFE, 12'd2040}
    };

    pwm_regctl u0 (
        .clk       (clk),
        .rst_n     (rst_n),
        .osc_clk   (osc_clk),
        .sleep     (sleep),
        .reg_addr  (reg_addr),
        .reg_we    (reg_we),
        .reg_wdata (reg_wdata),
        .reg_rdata (reg_rdata),
        .pwm_out   (pwm_out)
    );

    always #2.5 clk = ~clk;
    always #3.5 osc_clk = ~osc_clk;

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_run++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic wr(input logic a, input logic [7:0] d);
        @(negedge clk);
        reg_addr = a; reg_wdata = d; reg_we = 1'b1;
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic rd(input logic a, output logic [7:0] d);
        @(negedge clk);
        reg_addr = a;
        #1 d = reg_rdata;
    endtask

    // Enable with the given prescale and duty, then sample one period
    task automatic run_vec(input logic [3:0] sel, input logic [7:0] duty, input int exp);
        int hi = 0;
        int lead = 0;
        bit seen_low = 1'b0;
        wr(1'b0, 8'h00);
        wr(1'b1, duty);
        @(negedge clk);
        reg_addr = 1'b0; reg_wdata = 8'h80 | {4'h0, sel}; reg_we = 1'b1;
        for (int k = 1; k <= (256 << sel); k++) begin
            @(negedge clk);
            reg_we = 1'b0;
            if (pwm_out) begin
                hi++;
                if (!seen_low) lead++;
            end else begin
                seen_low = 1'b1;
            end
        end
        chk(hi == exp, "R3 high cycles per period", hi, exp);
        chk(lead == exp, "R4 contiguous high at period start", lead, exp);
        wr(1'b0, 8'h00);
    endtask

    // Count oscillator edges between two output changes
    task automatic osc_half(output int n);
        logic prev;
        int g = 0;
        prev = pwm_out;
        while (pwm_out == prev && g < 40) begin
            @(posedge osc_clk); #1; g++;
        end
        prev = pwm_out;
        n = 0;
        for (int i = 0; i < 40; i++) begin
            @(posedge osc_clk); #1; n++;
            if (pwm_out != prev) break;
        end
    endtask

    initial begin
        #(200000 * 5);
        if (!done) begin
            n_run++; n_fail++;
            $display("FAIL watchdog (all requirements) actual=timeout expected=completion");
            $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        logic [7:0] d;
        int n;
        int cnt;
        logic s1, s2;

        repeat (10) @(negedge clk);
        rst_n = 1'b1;

        // R1: reset state
        rd(1'b0, d); chk(d == 8'h00, "R1 control after reset", d, 0);
        rd(1'b1, d); chk(d == 8'h00, "R1 duty after reset", d, 0);
        chk(pwm_out == 1'b0, "R1 output after reset", pwm_out, 0);

        // R2: readback and reserved bit
        wr(1'b0, 8'hFF); rd(1'b0, d); chk(d == 8'hDF, "R2 control readback", d, 8'hDF);
        wr(1'b1, 8'hA5); rd(1'b1, d); chk(d == 8'hA5, "R2 duty readback", d, 8'hA5);
        wr(1'b0, 8'h00);

        // R5: idle level while disabled
        wr(1'b0, 8'h40); #1 chk(pwm_out == 1'b1, "R5 idle high when disabled", pwm_out, 1);
        wr(1'b0, 8'h00); #1 chk(pwm_out == 1'b0, "R5 idle low when disabled", pwm_out, 0);
        // R5: sleep overrides enable
        wr(1'b1, 8'h00);
        sleep = 1'b1;
        wr(1'b0, 8'hC0);
        cnt = 0;
        for (int k = 0; k < 20; k++) begin @(negedge clk); if (pwm_out) cnt++; end
        chk(cnt == 20, "R5 sleep holds idle high", cnt, 20);
        wr(1'b0, 8'h80);
        cnt = 0;
        for (int k = 0; k < 20; k++) begin @(negedge clk); if (pwm_out) cnt++; end
        chk(cnt == 0, "R5 sleep holds idle low", cnt, 0);
        sleep = 1'b0;
        wr(1'b0, 8'h00);

        // R6: square-wave mode, awake and asleep
        wr(1'b0, 8'h10);
        osc_half(n); chk(n == 8, "R6 oscillator edges per level", n, 8);
        sleep = 1'b1;
        osc_half(n); chk(n == 8, "R6 square wave during sleep", n, 8);
        sleep = 1'b0;
        wr(1'b0, 8'h00);

        // R3 / R4: vector table
        for (int v = 0; v < NVEC; v++) begin
            run_vec(VEC[v][23:20], VEC[v][19:12], int'(VEC[v][11:0]));
        end

        // R7: mid-period write, then a write on the wrap edge
        begin
            int lo_a = 0, hi_b = 0, hi_c = 0, hi_d = 0;
            wr(1'b1, 8'h0F);
            @(negedge clk);
            reg_addr = 1'b0; reg_wdata = 8'h80; reg_we = 1'b1;
            for (int k = 1; k <= 1024; k++) begin
                @(negedge clk);
                if (k > 100 && k <= 256 && !pwm_out) lo_a++;
                if (k > 256 && k <= 512 && pwm_out) hi_b++;
                if (k > 512 && k <= 768 && pwm_out) hi_c++;
                if (k > 768 && pwm_out) hi_d++;
                reg_we = 1'b0;
                if (k == 100) begin reg_addr = 1'b1; reg_wdata = 8'hFF; reg_we = 1'b1; end
                if (k == 512) begin reg_addr = 1'b1; reg_wdata = 8'h00; reg_we = 1'b1; end
            end
            chk(lo_a == 156, "R7 rest of period keeps old duty", lo_a, 156);
            chk(hi_b == 256, "R7 next period uses new duty", hi_b, 256);
            chk(hi_c == 256, "R7 write on wrap edge deferred", hi_c, 256);
            chk(hi_d == 1, "R7 deferred duty applied", hi_d, 1);
            wr(1'b0, 8'h00);
        end

        // R8: restart at count zero after sleep
        wr(1'b1, 8'h00);
        wr(1'b0, 8'h81);
        repeat (37) @(negedge clk);
        sleep = 1'b1;
        repeat (5) @(negedge clk);
        chk(pwm_out == 1'b0, "R8 idle while asleep", pwm_out, 0);
        sleep = 1'b0;
        @(negedge clk); s1 = pwm_out;
        @(negedge clk); s2 = pwm_out;
        chk(s1 == 1'b1, "R8 first sample after wake high", s1, 1);
        chk(s2 == 1'b0, "R8 low once count passes duty", s2, 0);

        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule